// File: doc/BRIEF.md
# Master clock source selector and divider

This block builds the two system clocks of a chip from one of three free-running sources: a slow clock, a main clock and a PLL output. The selected source passes through a prescaler with a fixed set of ratios. The result is the system clock. A post-divider then derives the master clock from the system clock.

Software writes a single configuration word that carries the source choice, the prescaler code and the post-divider value. Every change takes effect through a glitch-free sequence:

- All source gates are closed, each one at a low phase of its own clock.
- While no clock is running, the new ratios are loaded.
- Only the new source is reopened, through a synchronizer in its own domain.

A ready flag is low from the cycle after a changing write until the new setting is in force.

When the PLL is selected but reports no lock, the block runs from the slow clock and keeps ready low. When lock returns, the block moves back to the PLL and raises ready. A write that arrives in the middle of a switch is taken at once, and the sequence starts again toward the latest setting.

Top module: `sysclk_switch_div`

## Requirements
- R1: After reset the main clock is selected with both ratios 1, so the system clock and the master clock both have the main clock period, and ready is high.
- R2: Bits [1:0] of the configuration word select the source: 0 is the slow clock, 1 the main clock, 2 the PLL clock, and 3 is reserved and behaves as the slow clock.
- R3: Bits [4:2] hold the prescaler code, and codes 0 to 7 give ratios 1, 2, 3, 4, 8, 16, 32 and 64. The system clock period is the source period times that ratio.
- R4: Bits [6:5] hold a value m from 0 to 3, and the master clock period is the system clock period times m+1.
- R5: A write that changes any of the seven configuration bits makes ready low on the next cycle. A write of the value already held leaves ready high.
- R6: Ready rises only once the new source is running through the new ratios. From then on, both output periods match the new setting.
- R7: While the PLL is selected and not locked, the outputs run from the slow clock and ready stays low. After lock returns, the outputs run from the PLL again and ready goes high.
- R8: Switching is glitch-free. No output pulse is shorter than half a period of the fastest source, and at most one source gate is ever open.
- R9: Every ratio other than 1, odd ones included, gives an output whose high phase is half its period.
- R10: A write made while ready is low is accepted and restarts the switch, and the outputs settle on the most recent write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Clock of the configuration port and of the switching sequencer |
| rst | input | 1 | Synchronous active-high reset, held for at least two slow clock periods |
| slow_clk | input | 1 | Slow clock source |
| main_clk | input | 1 | Main clock source |
| pll_clk | input | 1 | PLL clock source |
| pll_locked | input | 1 | PLL lock indication, asynchronous |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 7 | Configuration word: source [1:0], prescaler code [4:2], post-divider [6:5] |
| hclk_out | output | 1 | Prescaled system clock |
| mclk_out | output | 1 | Master clock, the system clock post-divided |
| clk_ready | output | 1 | High when the outputs reflect the written configuration |

## Verification
A table of eleven configurations is written in turn. Between them, the table covers:

- each source;
- the bypass ratio, even and odd prescaler ratios and every post-divider value;
- the reserved source code.

Each entry is judged on the measured period and high phase of both outputs. This separates an ordering or off-by-one fault in the ratio table from a duty-cycle fault that affects only odd ratios.

Three directed patterns follow:

- A repeated identical write tells a compare-based ready drop from one that fires on every strobe.
- Back-to-back writes show whether a mid-switch write is taken or lost.
- Dropping and restoring PLL lock shows whether the slow-clock fallback and the hold on ready work.

An edge monitor on both outputs runs the whole time and flags any pulse shorter than the fastest half period.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;

  localparam int NUM_SRC  = 3;
  localparam int SRC_W    = 2;
  localparam int PRES_W   = 3;
  localparam int MDIV_W   = 2;
  localparam int SRC_LSB  = 0;
  localparam int PRES_LSB = SRC_LSB + SRC_W;
  localparam int MDIV_LSB = PRES_LSB + PRES_W;
  localparam int CFG_W    = SRC_W + PRES_W + MDIV_W;
  localparam int PRES_MAX = 64;
  localparam int MDIV_MAX = 1 << MDIV_W;
  localparam int PRES_RW  = $clog2(PRES_MAX + 1);
  localparam int MDIV_RW  = $clog2(MDIV_MAX + 1);

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  // reserved code behaves as the slow clock
  function automatic src_e src_decode(input logic [SRC_W-1:0] code);
    src_e s;
    s = src_e'(code);
    if (s == SRC_RSVD) s = SRC_SLOW;
    return s;
  endfunction

  // codes 0..3 -> 1..4, codes 4..7 -> 8,16,32,64
  function automatic logic [PRES_RW-1:0] pres_ratio(input logic [PRES_W-1:0] code);
    if (code < PRES_W'(4)) return PRES_RW'(code) + PRES_RW'(1);
    return PRES_RW'(1) << (code - PRES_W'(1));
  endfunction

  function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
    return NUM_SRC'(1) << s;
  endfunction

endpackage

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
// Per-source enable: request synchronized in the source domain, gate
// opened or closed on the falling edge so the gated clock never clips a high phase.
module clk_gate_cell #(
  parameter int SYNC_STAGES = 2,
  parameter bit START_ON    = 1'b0
) (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  output logic gated_clk,
  output logic gate_on
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  always_ff @(posedge src_clk) begin
    if (rst) sync_q <= {SYNC_STAGES{START_ON}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], req};
  end

  always_ff @(negedge src_clk) begin
    if (rst) en_q <= START_ON;
    else     en_q <= sync_q[SYNC_STAGES-1];
  end

  assign gated_clk = src_clk & en_q;
  assign gate_on   = en_q;

endmodule

// File: rtl/clk_ratio_div.sv
`timescale 1ns/1ps
// Runtime-ratio clock divider with 50% duty for every ratio.
// Ratio 1 passes the input through. The ratio only changes while the
// input clock is stopped.
module clk_ratio_div #(
  parameter  int MAX_RATIO = 64,
  localparam int CW        = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk_in,
  input  logic          rst,
  input  logic [CW-1:0] ratio,
  output logic          clk_out
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] hi_len;
  logic          a_q;
  logic          b_q;

  always_comb begin
    cnt_nxt = (cnt_q >= ratio - CW'(1)) ? '0 : cnt_q + CW'(1);
    hi_len  = (ratio >> 1) + CW'(ratio[0]);
  end

  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt_q <= '0;
      a_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      a_q   <= (cnt_nxt < hi_len);
    end
  end

  // half-cycle delayed copy; ANDed with a_q it trims an odd high phase by half a cycle
  always_ff @(negedge clk_in) begin
    if (rst) b_q <= 1'b0;
    else     b_q <= a_q;
  end

  assign clk_out = (ratio == CW'(1)) ? clk_in :
                   (ratio[0] ? (a_q & b_q) : a_q);

endmodule

// File: rtl/sysclk_switch_ctrl.sv
`timescale 1ns/1ps
module sysclk_switch_ctrl
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  input  logic               pll_locked,
  input  logic [NUM_SRC-1:0] src_on,
  output logic [NUM_SRC-1:0] src_req,
  output logic [PRES_RW-1:0] pres_div,
  output logic [MDIV_RW-1:0] mdiv_div,
  output logic               ready
);

  typedef enum logic [2:0] {
    PH_RUN, PH_STOP, PH_LOAD_PRES, PH_LOAD_MDIV, PH_START
  } phase_e;

  phase_e               phase_q, phase_d;
  logic [CFG_W-1:0]     cfg_q, cfg_d;
  src_e                 app_src_q;
  logic [PRES_W-1:0]    app_pres_q;
  logic [MDIV_W-1:0]    app_mdiv_q;
  logic [NUM_SRC-1:0]   req_q;
  logic                 ready_q, ready_d;
  logic [NUM_SRC-1:0]   ack_pipe [SYNC_STAGES];
  logic [NUM_SRC-1:0]   ack_s;
  logic [SYNC_STAGES-1:0] lock_pipe;
  logic                 lock_s;
  logic                 chg;
  src_e                 sel_q, sel_d, want_q, want_d;
  logic                 mismatch_d;

  // synchronizers into the sequencer domain
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) ack_pipe[k] <= src_onehot(SRC_MAIN);
      lock_pipe <= '0;
    end else begin
      ack_pipe[0] <= src_on;
      for (int k = 1; k < SYNC_STAGES; k++) ack_pipe[k] <= ack_pipe[k-1];
      lock_pipe <= {lock_pipe[SYNC_STAGES-2:0], pll_locked};
    end
  end
  assign ack_s  = ack_pipe[SYNC_STAGES-1];
  assign lock_s = lock_pipe[SYNC_STAGES-1];

  always_comb begin
    cfg_d  = wr_en ? wr_data : cfg_q;
    chg    = wr_en && (wr_data != cfg_q);
    sel_q  = src_decode(cfg_q[SRC_LSB +: SRC_W]);
    sel_d  = src_decode(cfg_d[SRC_LSB +: SRC_W]);
    want_q = (sel_q == SRC_PLL && !lock_s) ? SRC_SLOW : sel_q;
    want_d = (sel_d == SRC_PLL && !lock_s) ? SRC_SLOW : sel_d;
    mismatch_d = (want_d != app_src_q) ||
                 (cfg_d[PRES_LSB +: PRES_W] != app_pres_q) ||
                 (cfg_d[MDIV_LSB +: MDIV_W] != app_mdiv_q);
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_RUN:       if (chg || mismatch_d) phase_d = PH_STOP;
      PH_STOP:      if (ack_s == '0) phase_d = PH_LOAD_PRES;
      PH_LOAD_PRES: phase_d = PH_LOAD_MDIV;
      PH_LOAD_MDIV: phase_d = PH_START;
      PH_START: begin
        if (chg || mismatch_d)  phase_d = PH_STOP;
        else if (ack_s == req_q) phase_d = PH_RUN;
      end
      default:      phase_d = PH_STOP;
    endcase
    ready_d = (phase_d == PH_RUN) && (want_d == sel_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_RUN;
      cfg_q      <= CFG_W'(SRC_MAIN) << SRC_LSB;
      app_src_q  <= SRC_MAIN;
      app_pres_q <= '0;
      app_mdiv_q <= '0;
      req_q      <= src_onehot(SRC_MAIN);
      ready_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cfg_q   <= cfg_d;
      ready_q <= ready_d;
      if (phase_d == PH_STOP) req_q <= '0;
      // ratios change only while every gate is confirmed closed, one divider per step
      if (phase_q == PH_LOAD_PRES) app_pres_q <= cfg_q[PRES_LSB +: PRES_W];
      if (phase_q == PH_LOAD_MDIV) begin
        app_mdiv_q <= cfg_q[MDIV_LSB +: MDIV_W];
        app_src_q  <= want_q;
        req_q      <= src_onehot(want_q);
      end
    end
  end

  assign src_req  = req_q;
  assign pres_div = pres_ratio(app_pres_q);
  assign mdiv_div = MDIV_RW'(app_mdiv_q) + MDIV_RW'(1);
  assign ready    = ready_q;

  // R5: a changing write takes ready low on the next cycle
  a_r5_change_drops_ready: assert property (@(posedge clk) disable iff (rst)
    chg |=> !ready);

  // R7: PLL selected without lock never reports ready
  a_r7_unlock_holds_low: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SRC_PLL && !lock_s && !wr_en) |=> !ready);

  // R8: never two source gates open at once
  a_r8_one_gate_open: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_s));

  // R6: ready only with exactly the requested gate confirmed open
  a_r6_ready_has_source: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ack_s == req_q && $onehot(req_q)));

endmodule

// File: rtl/sysclk_switch_div.sv
`timescale 1ns/1ps
module sysclk_switch_div
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             cfg_clk,
  input  logic             rst,
  input  logic             slow_clk,
  input  logic             main_clk,
  input  logic             pll_clk,
  input  logic             pll_locked,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             hclk_out,
  output logic             mclk_out,
  output logic             clk_ready
);

  logic [NUM_SRC-1:0] src_clk_vec;
  logic [NUM_SRC-1:0] gated_vec;
  logic [NUM_SRC-1:0] gate_on_vec;
  logic [NUM_SRC-1:0] gate_req;
  logic [PRES_RW-1:0] pres_div;
  logic [MDIV_RW-1:0] mdiv_div;
  logic               mux_clk;
  logic               hclk_int;
  logic               mclk_int;

  assign src_clk_vec = {pll_clk, main_clk, slow_clk};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clk_gate_cell #(
      .SYNC_STAGES (SYNC_STAGES),
      .START_ON    (g == int'(SRC_MAIN))
    ) u_gate (
      .src_clk   (src_clk_vec[g]),
      .rst       (rst),
      .req       (gate_req[g]),
      .gated_clk (gated_vec[g]),
      .gate_on   (gate_on_vec[g])
    );
  end

  assign mux_clk = |gated_vec;

  sysclk_switch_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (cfg_clk),
    .rst        (rst),
    .wr_en      (cfg_we),
    .wr_data    (cfg_wdata),
    .pll_locked (pll_locked),
    .src_on     (gate_on_vec),
    .src_req    (gate_req),
    .pres_div   (pres_div),
    .mdiv_div   (mdiv_div),
    .ready      (clk_ready)
  );

  clk_ratio_div #(.MAX_RATIO(PRES_MAX)) u_pres (
    .clk_in  (mux_clk),
    .rst     (rst),
    .ratio   (pres_div),
    .clk_out (hclk_int)
  );

  clk_ratio_div #(.MAX_RATIO(MDIV_MAX)) u_mdiv (
    .clk_in  (hclk_int),
    .rst     (rst),
    .ratio   (mdiv_div),
    .clk_out (mclk_int)
  );

  assign hclk_out = hclk_int;
  assign mclk_out = mclk_int;

endmodule

// File: tb/sysclk_switch_div_bench.sv
`timescale 1ns/1ps
module sysclk_switch_div_bench;
  import sysclk_pkg::*;

  localparam realtime T_CFG  = 4.0;
  localparam realtime T_MAIN = 10.0;
  localparam realtime T_PLL  = 6.0;
  localparam realtime T_SLOW = 64.0;
  localparam realtime MIN_PULSE = 2.9;
  localparam int NV = 11;

  // entry: {exp_src[1:0], mdiv_ratio[2:0], pres_ratio[7:0], m[1:0], p[2:0], s[1:0]}
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 3'd1, 8'd2,  2'd0, 3'd1, 2'd1},
    {2'd2, 3'd2, 8'd3,  2'd1, 3'd2, 2'd2},
    {2'd0, 3'd1, 8'd1,  2'd0, 3'd0, 2'd0},
    {2'd1, 3'd4, 8'd8,  2'd3, 3'd4, 2'd1},
    {2'd2, 3'd3, 8'd1,  2'd2, 3'd0, 2'd2},
    {2'd0, 3'd2, 8'd2,  2'd1, 3'd1, 2'd3},
    {2'd2, 3'd1, 8'd64, 2'd0, 3'd7, 2'd2},
    {2'd1, 3'd3, 8'd4,  2'd2, 3'd3, 2'd1},
    {2'd2, 3'd1, 8'd16, 2'd0, 3'd5, 2'd2},
    {2'd1, 3'd2, 8'd32, 2'd1, 3'd6, 2'd1},
    {2'd0, 3'd3, 8'd3,  2'd2, 3'd2, 2'd0}
  };

  logic cfg_clk = 1'b0, slow_clk = 1'b0, main_clk = 1'b0, pll_clk = 1'b0;
  logic rst = 1'b1, pll_locked = 1'b1, cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic hclk_out, mclk_out, clk_ready;

  int checks = 0, errors = 0, glitches = 0;
  realtime last_h = -100.0, last_m = -100.0;

  sysclk_switch_div u_sysclk_switch_div (
    .cfg_clk(cfg_clk), .rst(rst), .slow_clk(slow_clk), .main_clk(main_clk),
    .pll_clk(pll_clk), .pll_locked(pll_locked), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .hclk_out(hclk_out), .mclk_out(mclk_out),
    .clk_ready(clk_ready)
  );

  always #(T_CFG/2) cfg_clk = ~cfg_clk;
  initial begin #1.3; forever #(T_MAIN/2) main_clk = ~main_clk; end
  initial begin #0.7; forever #(T_PLL/2)  pll_clk  = ~pll_clk;  end
  initial begin #2.1; forever #(T_SLOW/2) slow_clk = ~slow_clk; end

  // R8 pulse-width monitor on both outputs
  always @(hclk_out) begin
    if (!rst && ($realtime - last_h) < MIN_PULSE) glitches++;
    last_h = $realtime;
  end
  always @(mclk_out) begin
    if (!rst && ($realtime - last_m) < MIN_PULSE) glitches++;
    last_m = $realtime;
  end

  task automatic chk(input bit ok, input string tag, input realtime act, input realtime exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_time(input string tag, input realtime act, input realtime exp);
    chk((act - exp) < 0.05 && (exp - act) < 0.05, tag, act, exp);
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] d);
    @(negedge cfg_clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge cfg_clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge cfg_clk);
      if (clk_ready) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(input bit use_m, output realtime per, output realtime hi);
    realtime t0, t1, t2;
    if (use_m) begin
      repeat (2) @(posedge mclk_out);
      t0 = $realtime; @(negedge mclk_out); t1 = $realtime; @(posedge mclk_out); t2 = $realtime;
    end else begin
      repeat (2) @(posedge hclk_out);
      t0 = $realtime; @(negedge hclk_out); t1 = $realtime; @(posedge hclk_out); t2 = $realtime;
    end
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  function automatic realtime src_period(input logic [1:0] es);
    if (es == 2'd0) return T_SLOW;
    if (es == 2'd1) return T_MAIN;
    return T_PLL;
  endfunction

  task automatic check_outputs(input string tag, input realtime exp_h, input realtime exp_m);
    realtime per, hi;
    measure(1'b0, per, hi);
    chk_time({tag, " R3 hclk period"}, per, exp_h);
    chk_time({tag, " R9 hclk high phase"}, hi, exp_h / 2.0);
    measure(1'b1, per, hi);
    chk_time({tag, " R4 R6 mclk period"}, per, exp_m);
    chk_time({tag, " R9 mclk high phase"}, hi, exp_m / 2.0);
  endtask

  initial begin
    #(200000 * T_CFG);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    realtime per, hi;
    repeat (50) @(negedge cfg_clk);
    rst = 1'b0;
    repeat (3) @(negedge cfg_clk);

    // R1 reset state
    chk(clk_ready == 1'b1, "R1 ready after reset", real'(clk_ready), 1.0);
    check_outputs("R1 reset", T_MAIN, T_MAIN);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      realtime eh;
      v = VEC[i];
      write_cfg(v[6:0]);
      chk(clk_ready == 1'b0, $sformatf("R5 vec%0d ready drop", i), real'(clk_ready), 0.0);
      wait_ready(ok);
      chk(ok, $sformatf("R6 vec%0d ready rises", i), real'(ok), 1.0);
      eh = src_period(v[19:18]) * real'(v[14:7]);
      check_outputs($sformatf("R2 vec%0d", i), eh, eh * real'(v[17:15]));
    end

    // R10: second write during a switch restarts toward it
    write_cfg(7'b00_001_01);
    repeat (2) @(negedge cfg_clk);
    write_cfg(7'b01_011_10);
    chk(clk_ready == 1'b0, "R10 ready low after second write", real'(clk_ready), 0.0);
    wait_ready(ok);
    chk(ok, "R10 ready after restart", real'(ok), 1.0);
    check_outputs("R10 last write", T_PLL * 4.0, T_PLL * 8.0);

    // R5: identical write keeps ready
    write_cfg(7'b01_011_10);
    chk(clk_ready == 1'b1, "R5 same write ready stays", real'(clk_ready), 1.0);
    repeat (5) @(negedge cfg_clk);
    chk(clk_ready == 1'b1, "R5 same write ready later", real'(clk_ready), 1.0);

    // R7: lock loss falls back to slow clock
    @(negedge cfg_clk);
    pll_locked = 1'b0;
    repeat (10) @(negedge cfg_clk);
    chk(clk_ready == 1'b0, "R7 ready low on unlock", real'(clk_ready), 0.0);
    repeat (300) @(negedge cfg_clk);
    measure(1'b0, per, hi);
    chk_time("R7 hclk from slow clock", per, T_SLOW * 4.0);
    measure(1'b1, per, hi);
    chk_time("R7 mclk from slow clock", per, T_SLOW * 8.0);
    @(negedge cfg_clk);
    chk(clk_ready == 1'b0, "R7 ready held low", real'(clk_ready), 0.0);
    pll_locked = 1'b1;
    wait_ready(ok);
    chk(ok, "R7 ready after relock", real'(ok), 1.0);
    check_outputs("R7 relocked", T_PLL * 4.0, T_PLL * 8.0);

    // R8 no runt pulses across every switch above
    chk(glitches == 0, "R8 short pulses", real'(glitches), 0.0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule